// File: doc/BRIEF.md
# Variable Pulse Width Receive Symbol Classifier

This block watches a single-wire bus that carries variable pulse width modulated traffic. It resynchronises the raw bus level to the system clock and passes it through a digital filter. It then counts, in sampling ticks, how long each active (high) and passive (low) level lasts. When a level ends, its polarity and its length together pick the symbol: a data bit, a start-of-frame, or an invalid pulse. While the bus is held passive, the running length also marks end-of-data and end-of-frame as soon as each threshold is crossed.

The decision windows touch one another with no gap, and every boundary belongs to exactly one symbol. A sampling tick (`tickEn`, one pulse per microsecond at the default settings) advances both the filter and the length counter. Every output is a one-clock strobe. A byte assembler further down the receive path consumes them.

With the default parameters, lengths of 34 to 95 ticks are short, 96 to 162 are long, and 163 to 238 fall in the start-of-frame window. A passive level reaches end-of-data at 163 ticks and end-of-frame at 239 ticks.

Top module: `vpw_symbol_rx`

## Requirements
- R1: A change of the raw bus level that lasts fewer than FILT_LEN consecutive ticks after synchronisation is ignored. It produces no strobe and does not split the length of the level around it.
- R2: An active pulse whose length L satisfies SOF_MIN <= L < EOF_MIN raises `sofStb` in any state and enters the in-frame state.
- R3: In frame, a passive level ended by a rising edge gives `bitStb` with `bitVal`=0 for MIN_LEN <= L < LONG_MIN, and with `bitVal`=1 for LONG_MIN <= L < SOF_MIN.
- R4: In frame, an active pulse gives `bitStb` with `bitVal`=1 for MIN_LEN <= L < LONG_MIN, and with `bitVal`=0 for LONG_MIN <= L < SOF_MIN.
- R5: An active pulse with L < MIN_LEN in any state, or a passive level with L < MIN_LEN in frame, raises `errStb` and returns the block to idle. From idle it waits for the next start-of-frame.
- R6: In frame, `eodStb` fires exactly once per passive level, at the tick on which that level has lasted SOF_MIN ticks. A passive level of SOF_MIN <= L < EOF_MIN that is then ended by a rising edge yields no bit, and the frame continues.
- R7: In frame, a passive level reaching EOF_MIN ticks raises `eofStb`, EOF_MIN - SOF_MIN ticks after `eodStb`, and returns to idle. In idle, pulses outside the start-of-frame window produce no bit.
- R8: An active level reaching EOF_MIN ticks raises `errStb` once at that tick and returns to idle. The length counter saturates, so its later release produces no further strobe.
- R9: In idle, an active pulse with MIN_LEN <= L < SOF_MIN and all passive levels produce no strobe.
- R10: During reset and after it, with the bus passive, all strobes are low.
- R11: At most one of `bitStb`, `sofStb`, `eodStb`, `eofStb`, `errStb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Sampling tick enable; one tick is one length unit |
| busRaw | input | 1 | Raw bus level, 1 = active |
| bitStb | output | 1 | Decoded data bit strobe |
| bitVal | output | 1 | Value of the decoded bit, valid with `bitStb` |
| sofStb | output | 1 | Start-of-frame strobe |
| eodStb | output | 1 | End-of-data strobe |
| eofStb | output | 1 | End-of-frame strobe |
| errStb | output | 1 | Invalid pulse strobe |

## Verification
The bench sweeps every passive length and every active length, one tick at a time, across all windows of a reduced configuration. This covers each shared boundary, where an off-by-one compare would hand a pulse to the wrong neighbour: a 0 instead of a 1, a bit where end-of-data belongs, or a start-of-frame where an error belongs. Each sweep checks the strobes that follow as well as the classified pulse. A design that failed to return to idle after an error, or that kept decoding after end-of-frame, would emit extra bits. Glitches shorter than the filter are placed inside pulses, so a missing filter shows up as runt errors or split bits. The spacing of the end-of-data and end-of-frame strobes is measured in cycles, and so is their distance from the last edge. A counter that wraps, or fires late by one, breaks those distances or repeats the overlong error.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FRAME = 1'b1
  } rxStateT;

  // Datapath to control: tick, edge and length comparisons for the level
  // that is ending (or still running) in this cycle.
  typedef struct packed {
    logic tick;      // sampling tick this cycle
    logic turn;      // filtered level flips at this tick
    logic active;    // current (ending) level is active
    logic runt;      // length below the shortest valid pulse
    logic shortLen;  // length below the long window
    logic longLen;   // length below the start-of-frame window
    logic sofLen;    // length below the end-of-frame threshold
    logic atEod;     // length equals the end-of-data threshold
    logic atEof;     // length equals the end-of-frame threshold
  } pulseMeasT;

  typedef struct packed {
    logic bitStb;
    logic bitVal;
    logic sof;
    logic eod;
    logic eof;
    logic err;
  } rxStrobeT;

endpackage

// File: rtl/vpw_rx_datapath.sv
module vpw_rx_datapath
  import vpw_rx_pkg::*;
#(
  parameter int FILT_LEN = 2,
  parameter int MIN_LEN  = 34,
  parameter int LONG_MIN = 96,
  parameter int SOF_MIN  = 163,
  parameter int EOF_MIN  = 239
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      busRaw,
  output pulseMeasT meas
);

  localparam int CNT_MAX = EOF_MIN + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int FW      = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic          lvlQ;
  logic [FW-1:0] filtCnt;
  logic [CW-1:0] lenCnt;
  logic          differ;
  logic          lvlTurn;

  // two-flop synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[0], busRaw};
  end

  assign differ  = syncQ[1] != lvlQ;
  assign lvlTurn = tickEn && differ && (filtCnt == FW'(FILT_LEN - 1));

  // digital filter: the new level must persist FILT_LEN ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ    <= 1'b0;
      filtCnt <= '0;
    end else if (tickEn) begin
      if (lvlTurn) begin
        lvlQ    <= syncQ[1];
        filtCnt <= '0;
      end else if (differ) begin
        filtCnt <= filtCnt + FW'(1);
      end else begin
        filtCnt <= '0;
      end
    end
  end

  // saturating length counter; holds L at the tick that ends a level of L ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenCnt <= CW'(CNT_MAX);
    end else if (tickEn) begin
      if (lvlTurn)                    lenCnt <= CW'(1);
      else if (lenCnt != CW'(CNT_MAX)) lenCnt <= lenCnt + CW'(1);
    end
  end

  always_comb begin
    meas.tick     = tickEn;
    meas.turn     = lvlTurn;
    meas.active   = lvlQ;
    meas.runt     = lenCnt < CW'(MIN_LEN);
    meas.shortLen = lenCnt < CW'(LONG_MIN);
    meas.longLen  = lenCnt < CW'(SOF_MIN);
    meas.sofLen   = lenCnt < CW'(EOF_MIN);
    meas.atEod    = lenCnt == CW'(SOF_MIN);
    meas.atEof    = lenCnt == CW'(EOF_MIN);
  end

  AST_LVL_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (lvlQ != $past(lvlQ)) |-> $past(tickEn)) else $error("level moved off tick"); // R1
  AST_LVL_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (lvlQ != $past(lvlQ)) |-> (lvlQ == $past(syncQ[1]))) else $error("level not from sync"); // R1
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (lenCnt == CW'(CNT_MAX) && !lvlTurn) |=> (lenCnt == CW'(CNT_MAX))) else $error("counter wrapped"); // R8

endmodule

// File: rtl/vpw_rx_ctrl.sv
module vpw_rx_ctrl
  import vpw_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pulseMeasT meas,
  output logic      bitStb,
  output logic      bitVal,
  output logic      sofStb,
  output logic      eodStb,
  output logic      eofStb,
  output logic      errStb
);

  rxStateT  stateQ, stateD;
  rxStrobeT stbQ, stbD;

  always_comb begin
    stateD = stateQ;
    stbD   = '0;
    if (meas.tick) begin
      if (meas.active) begin
        if (meas.atEof) begin
          stbD.err = 1'b1;
          stateD   = ST_IDLE;
        end else if (meas.turn) begin
          if (meas.runt) begin
            stbD.err = 1'b1;
            stateD   = ST_IDLE;
          end else if (!meas.longLen && meas.sofLen) begin
            stbD.sof = 1'b1;
            stateD   = ST_FRAME;
          end else if (stateQ == ST_FRAME && meas.longLen) begin
            stbD.bitStb = 1'b1;
            stbD.bitVal = meas.shortLen;
          end
        end
      end else if (stateQ == ST_FRAME) begin
        if (meas.atEod) stbD.eod = 1'b1;
        if (meas.atEof) begin
          stbD.eof = 1'b1;
          stateD   = ST_IDLE;
        end else if (meas.turn) begin
          if (meas.runt) begin
            stbD.err = 1'b1;
            stateD   = ST_IDLE;
          end else if (meas.longLen) begin
            stbD.bitStb = 1'b1;
            stbD.bitVal = !meas.shortLen;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      stbQ   <= '0;
    end else begin
      stateQ <= stateD;
      stbQ   <= stbD;
    end
  end

  assign bitStb = stbQ.bitStb;
  assign bitVal = stbQ.bitVal;
  assign sofStb = stbQ.sof;
  assign eodStb = stbQ.eod;
  assign eofStb = stbQ.eof;
  assign errStb = stbQ.err;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bitStb, sofStb, eodStb, eofStb, errStb})) else $error("strobes overlap"); // R11
  AST_SOF_ENTERS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    sofStb |-> stateQ == ST_FRAME) else $error("sof without frame"); // R2
  AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    bitStb |-> (stateQ == ST_FRAME && $past(stateQ) == ST_FRAME)) else $error("bit outside frame"); // R3
  AST_EOF_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    eofStb |-> ($past(stateQ) == ST_FRAME && stateQ == ST_IDLE)) else $error("eof state"); // R7
  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    errStb |-> stateQ == ST_IDLE) else $error("error kept frame"); // R5
  AST_NO_ERR_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    errStb |=> !errStb) else $error("error repeated"); // R8

endmodule

// File: rtl/vpw_symbol_rx.sv
module vpw_symbol_rx
  import vpw_rx_pkg::*;
#(
  parameter int FILT_LEN = 2,
  parameter int MIN_LEN  = 34,
  parameter int LONG_MIN = 96,
  parameter int SOF_MIN  = 163,
  parameter int EOF_MIN  = 239
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic busRaw,
  output logic bitStb,
  output logic bitVal,
  output logic sofStb,
  output logic eodStb,
  output logic eofStb,
  output logic errStb
);

  pulseMeasT meas;

  vpw_rx_datapath #(
    .FILT_LEN(FILT_LEN), .MIN_LEN(MIN_LEN), .LONG_MIN(LONG_MIN),
    .SOF_MIN(SOF_MIN),   .EOF_MIN(EOF_MIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busRaw(busRaw), .meas(meas)
  );

  vpw_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .meas(meas),
    .bitStb(bitStb), .bitVal(bitVal), .sofStb(sofStb),
    .eodStb(eodStb), .eofStb(eofStb), .errStb(errStb)
  );

endmodule

// File: tb/sim_vpw_symbol_rx.sv
`timescale 1ns/1ps
module sim_vpw_symbol_rx;

  localparam int F  = 2;
  localparam int MN = 4;
  localparam int LG = 8;
  localparam int SF = 12;
  localparam int EF = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic busRaw = 1'b0;
  logic bitStb, bitVal, sofStb, eodStb, eofStb, errStb;

  always #2 clk = ~clk;

  vpw_symbol_rx #(.FILT_LEN(F), .MIN_LEN(MN), .LONG_MIN(LG), .SOF_MIN(SF), .EOF_MIN(EF)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busRaw(busRaw),
    .bitStb(bitStb), .bitVal(bitVal), .sofStb(sofStb),
    .eodStb(eodStb), .eofStb(eofStb), .errStb(errStb));

  int nChk = 0, nBad = 0;
  int cyc = 0, nBit = 0, nSof = 0, nEod = 0, nEof = 0, nErr = 0;
  int bitCyc = 0, eodCyc = 0, eofCyc = 0;
  logic bitLog [0:1023];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (bitStb) begin bitLog[nBit] <= bitVal; nBit <= nBit + 1; bitCyc <= cyc; end
      if (sofStb) nSof <= nSof + 1;
      if (eodStb) begin nEod <= nEod + 1; eodCyc <= cyc; end
      if (eofStb) begin nEof <= nEof + 1; eofCyc <= cyc; end
      if (errStb) nErr <= nErr + 1;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drv(input logic lvl, input int len);
    @(negedge clk) busRaw = lvl;
    repeat (len - 1) @(negedge clk);
  endtask

  int b0, s0, d0, f0, e0;
  task automatic mark();
    repeat (2) @(negedge clk);
    b0 = nBit; s0 = nSof; d0 = nEod; f0 = nEof; e0 = nErr;
  endtask

  task automatic expect5(input string tag, input int eb, input int es, input int ed,
                         input int ef, input int ee);
    repeat (8) @(negedge clk);
    chk({tag, " bits"}, nBit - b0, eb);
    chk({tag, " sof"},  nSof - s0, es);
    chk({tag, " eod"},  nEod - d0, ed);
    chk({tag, " eof"},  nEof - f0, ef);
    chk({tag, " err"},  nErr - e0, ee);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: got 1 expected 0");
    finishRun();
  end

  initial begin
    // R10: reset state
    repeat (4) @(negedge clk);
    chk("R10 reset strobes", int'({bitStb, sofStb, eodStb, eofStb, errStb}), 0);
    rstN = 1'b1;
    mark();
    repeat (30) @(negedge clk);
    expect5("R10 idle after reset", 0, 0, 0, 0, 0);

    // idle sweep over active lengths: R2, R5, R8, R9
    for (int la = F; la <= EF + 2; la++) begin
      automatic bit isErr = (la < MN) || (la >= EF);
      automatic bit isSof = (la >= SF) && (la < EF);
      mark();
      drv(1'b1, la); drv(1'b0, 20);
      expect5(isErr ? "R8 R5 idle active" : (isSof ? "R2 idle sof" : "R9 idle ignore"),
              0, int'(isSof), int'(isSof), int'(isSof), int'(isErr));
    end

    // in-frame passive sweep: R3, R5, R6, R7
    for (int lp = F; lp <= EF + 2; lp++) begin
      automatic int eb, ed, ee, v0;
      mark();
      drv(1'b1, SF); drv(1'b0, lp); drv(1'b1, 5); drv(1'b0, 20);
      if (lp < MN)      begin eb = 0; ed = 0; ee = 1; v0 = 0; end
      else if (lp < LG) begin eb = 2; ed = 1; ee = 0; v0 = 0; end
      else if (lp < SF) begin eb = 2; ed = 1; ee = 0; v0 = 1; end
      else if (lp < EF) begin eb = 1; ed = 2; ee = 0; v0 = 1; end
      else              begin eb = 0; ed = 1; ee = 0; v0 = 0; end
      expect5("R3 R6 R7 passive sweep", eb, 1, ed, (lp < MN) ? 0 : 1, ee);
      if (eb > 0) chk("R3 passive bit value", int'(bitLog[b0]), v0);
      if (eb > 1) chk("R4 following short active", int'(bitLog[b0 + 1]), 1);
    end

    // in-frame active sweep: R4, R2, R5, R8
    for (int la = F; la <= EF + 2; la++) begin
      automatic int eb = 2, es = 1, ee = 0, ed = 1, v1 = 0;
      mark();
      drv(1'b1, SF); drv(1'b0, 5); drv(1'b1, la); drv(1'b0, 20);
      if (la < MN)      begin eb = 1; ee = 1; ed = 0; end
      else if (la < LG) v1 = 1;
      else if (la < SF) v1 = 0;
      else if (la < EF) begin eb = 1; es = 2; end
      else              begin eb = 1; ee = 1; ed = 0; end
      expect5("R4 R8 active sweep", eb, es, ed, ed, ee);
      chk("R3 first passive bit", int'(bitLog[b0]), 0);
      if (eb > 1) chk("R4 active bit value", int'(bitLog[b0 + 1]), v1);
    end

    // R1: glitches shorter than the filter inside a passive bit and a start pulse
    mark();
    drv(1'b1, SF); drv(1'b0, 3); drv(1'b1, 1); drv(1'b0, 3); drv(1'b1, 5); drv(1'b0, 24);
    expect5("R1 glitch in frame", 2, 1, 1, 1, 0);
    chk("R1 merged passive is 0", int'(bitLog[b0]), 0);
    chk("R1 active after glitch", int'(bitLog[b0 + 1]), 1);
    chk("R6 eod distance from last edge", eodCyc - bitCyc, SF);
    chk("R7 eof after eod", eofCyc - eodCyc, EF - SF);
    mark();
    drv(1'b1, 6); drv(1'b0, 1); drv(1'b1, 7); drv(1'b0, 24);
    expect5("R1 glitch in start pulse", 0, 1, 1, 1, 0);

    // R7: after end-of-frame, bit-length pulses decode nothing
    mark();
    drv(1'b1, 5); drv(1'b0, 9); drv(1'b1, 9); drv(1'b0, 20);
    expect5("R7 idle no bits", 0, 0, 0, 0, 0);

    finishRun();
  end

endmodule